// File: doc/BRIEF.md
# Frame Sync Pulse Generator

This block divides its clock by a programmable ratio N and drives one output pin with a frame-sync pulse that repeats every N cycles. The active time of the pulse is set in whole clock cycles or by a half-period selector, and its active level is chosen by a polarity input. A strobe puts the pulse phase back to the start of a period, so the pulse can be lined up with an external frame boundary.

The pulse width, the half-period selector and the divider ratio are written into shadow registers and copied to the working set as a group. One configuration-valid input controls the copy. While it is low, writes are taken into the shadow set and the output keeps using the old values. After it goes high, the new set takes over at the next period boundary, so a period is never cut short by a change in configuration. A mode input turns the block into a plain divided clock. In that mode the alignment strobe is ignored, but the width and polarity controls still apply.

Top module: `fsync_pulse_gen`

## Requirements
- R1: After reset the working set is ratio 8, width 1 and half-period off, and the first clock cycle after reset release is count 0 of a period.
- R2: The count runs from 0 to N-1 and wraps. The output is active during counts 0 to W-1 of every period, where W is the effective width.
- R3: When `pol_i` is 1 the active level is high and the idle level is low. When it is 0 both levels are inverted. Polarity is not shadowed and applies in the same cycle.
- R4: When the half-period selector is 1, the effective width is floor(N/2), whatever the explicit width field holds. For N=7 this gives 3 active cycles and for N=8 it gives 4.
- R5: An explicit width of 0 acts as 1, and a width of N or more acts as N-1. A ratio below 2 is taken as 2 when it is copied to the working set.
- R6: Writes to the shadow width, half-period selector or ratio are accepted only while `cfg_valid_i` is 0. Writes made while it is 1 are ignored.
- R7: While `cfg_valid_i` is 0 the output keeps using the working set. After a 0-to-1 transition, the shadow set is copied at the end of the first count N-1 cycle that is not an alignment cycle. The next period then runs with the new ratio and width.
- R8: In frame mode (`clk_mode_i`=0), a cycle with `align_i`=1 is count 0 of a new period, and the output is active in that same cycle. The count continues from 1 in the following cycle.
- R9: In clock mode (`clk_mode_i`=1), `align_i` has no effect and the count keeps running freely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_mode_i | input | 1 | 0 = frame mode, 1 = plain clock mode |
| align_i | input | 1 | Phase restart strobe, used only in frame mode |
| cfg_valid_i | input | 1 | 0 = shadow set open for writes, 1 = shadow set committed |
| wr_width_en_i | input | 1 | Write strobe for the width and half-period selector |
| wr_width_i | input | 10 | New pulse width in cycles |
| wr_half_i | input | 1 | New half-period selector |
| wr_ratio_en_i | input | 1 | Write strobe for the ratio |
| wr_ratio_i | input | 10 | New divider ratio N |
| pol_i | input | 1 | Active level: 1 = high, 0 = low |
| fsync_o | output | 1 | Frame-sync or divided-clock output |

## Verification
The bench targets the handover from old to new configuration. It raises the valid input in the same cycle as an alignment, so a design that copies the new set at once would reshape the period in progress. A design that copies at the wrong boundary would show the wrong ratio one period early or late. Odd-ratio half-period settings and out-of-range widths are driven so that rounding up, or failing to clamp, shows up as an extra or missing active cycle. Writes made while the valid input is high, and alignment strobes in clock mode, are checked for no effect on the output; a design that lets them through would shift the pattern or change its width.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
   localparam int unsigned PW_W = 10;
   localparam int unsigned N_W  = 10;

   typedef logic [PW_W-1:0] pw_t;
   typedef logic [N_W-1:0]  ratio_t;

   typedef struct packed {
      pw_t    width;
      logic   half;
      ratio_t ratio;
   } fsg_cfg_t;

   typedef enum logic {
      MODE_FRAME = 1'b0,
      MODE_CLOCK = 1'b1
   } fsg_mode_e;
endpackage

// File: rtl/fsg_cfg_shadow.sv
module fsg_cfg_shadow
   import fsg_pkg::*;
#(
   parameter int unsigned RST_RATIO = 8,
   parameter int unsigned RST_WIDTH = 1,
   parameter bit          RST_HALF  = 1'b0,
   parameter int unsigned MIN_RATIO = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      valid_i,
   input  logic      wr_width_en_i,
   input  pw_t       wr_width_i,
   input  logic      wr_half_i,
   input  logic      wr_ratio_en_i,
   input  ratio_t    wr_ratio_i,
   input  logic      wrap_i,
   output fsg_cfg_t  act_o
);
   localparam fsg_cfg_t RST_CFG = '{width: pw_t'(RST_WIDTH),
                                    half:  RST_HALF,
                                    ratio: ratio_t'(RST_RATIO)};
   localparam ratio_t   FLOOR_N = ratio_t'(MIN_RATIO);

   fsg_cfg_t shd_q, act_q;
   logic     valid_q, pend_q;
   logic     rise, pend_nxt, load;
   ratio_t   ratio_safe;

   assign rise       = valid_i & ~valid_q;
   assign pend_nxt   = pend_q | rise;
   assign load       = wrap_i & pend_nxt & valid_i;
   assign ratio_safe = (shd_q.ratio < FLOOR_N) ? FLOOR_N : shd_q.ratio;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b1;
         pend_q  <= 1'b0;
      end else begin
         valid_q <= valid_i;
         pend_q  <= valid_i & ~load & pend_nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shd_q <= RST_CFG;
      end else if (!valid_i) begin
         if (wr_width_en_i) begin
            shd_q.width <= wr_width_i;
            shd_q.half  <= wr_half_i;
         end
         if (wr_ratio_en_i) begin
            shd_q.ratio <= wr_ratio_i;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= RST_CFG;
      end else if (load) begin
         act_q.width <= shd_q.width;
         act_q.half  <= shd_q.half;
         act_q.ratio <= ratio_safe;
      end
   end

   assign act_o = act_q;

   AST_SHADOW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i |=> $stable(shd_q)); // R6
   AST_HOLD_WHILE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> $stable(act_q)); // R7
endmodule

// File: rtl/fsg_period_ctr.sv
module fsg_period_ctr
   import fsg_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  ratio_t n_i,
   input  logic   align_i,
   output ratio_t cnt_o,
   output logic   wrap_o
);
   ratio_t cnt_q;
   ratio_t last;

   assign last   = n_i - ratio_t'(1);
   assign wrap_o = (cnt_q == last) & ~align_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (align_i) begin
         cnt_q <= ratio_t'(1);
      end else if (wrap_o) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + ratio_t'(1);
      end
   end

   assign cnt_o = cnt_q;

   AST_CNT_BELOW_N: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < n_i); // R2
endmodule

// File: rtl/fsg_pulse_shaper.sv
module fsg_pulse_shaper
   import fsg_pkg::*;
#(
   parameter bit OUT_REG = 1'b0
) (
   input  logic     clk,
   input  logic     rst_n,
   input  ratio_t   cnt_i,
   input  fsg_cfg_t cfg_i,
   input  logic     align_i,
   input  logic     pol_i,
   output logic     fsync_o
);
   localparam int unsigned CW = (PW_W > N_W) ? PW_W : N_W;
   typedef logic [CW-1:0] cmp_t;

   cmp_t w_eff, raw_w, lim_w, half_w;
   logic active, level;

   always_comb begin
      raw_w  = cmp_t'(cfg_i.width);
      lim_w  = cmp_t'(cfg_i.ratio) - cmp_t'(1);
      half_w = cmp_t'(cfg_i.ratio >> 1);
      if (cfg_i.half) begin
         w_eff = half_w;
      end else if (raw_w == '0) begin
         w_eff = cmp_t'(1);
      end else if (raw_w > lim_w) begin
         w_eff = lim_w;
      end else begin
         w_eff = raw_w;
      end
   end

   assign active = align_i | (cmp_t'(cnt_i) < w_eff);
   assign level  = pol_i ? active : ~active;

   generate
      if (OUT_REG) begin : g_reg_out
         logic fs_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) fs_q <= 1'b0;
            else        fs_q <= level;
         end
         assign fsync_o = fs_q;
      end else begin : g_comb_out
         assign fsync_o = level;
      end
   endgenerate

   AST_WIDTH_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (w_eff != '0) && (w_eff < cmp_t'(cfg_i.ratio))); // R5
endmodule

// File: rtl/fsync_pulse_gen.sv
module fsync_pulse_gen
   import fsg_pkg::*;
#(
   parameter int unsigned RST_RATIO = 8,
   parameter int unsigned RST_WIDTH = 1,
   parameter bit          RST_HALF  = 1'b0,
   parameter int unsigned MIN_RATIO = 2,
   parameter bit          OUT_REG   = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clk_mode_i,
   input  logic        align_i,
   input  logic        cfg_valid_i,
   input  logic        wr_width_en_i,
   input  logic [9:0]  wr_width_i,
   input  logic        wr_half_i,
   input  logic        wr_ratio_en_i,
   input  logic [9:0]  wr_ratio_i,
   input  logic        pol_i,
   output logic        fsync_o
);
   localparam int unsigned N_MAX = (1 << N_W) - 1;

   if (MIN_RATIO < 2) begin : g_bad_min
      $error("MIN_RATIO must be at least 2");
   end
   if (RST_RATIO < MIN_RATIO || RST_RATIO > N_MAX) begin : g_bad_rst
      $error("RST_RATIO out of range");
   end
   if (PW_W != 10 || N_W != 10) begin : g_bad_w
      $error("port widths assume 10-bit fields");
   end

   fsg_mode_e mode;
   fsg_cfg_t  act_cfg;
   ratio_t    cnt;
   logic      wrap, align_eff;

   assign mode      = fsg_mode_e'(clk_mode_i);
   assign align_eff = align_i & (mode == MODE_FRAME);

   fsg_cfg_shadow #(
      .RST_RATIO(RST_RATIO), .RST_WIDTH(RST_WIDTH),
      .RST_HALF(RST_HALF),   .MIN_RATIO(MIN_RATIO)
   ) u_shadow (
      .clk(clk), .rst_n(rst_n), .valid_i(cfg_valid_i),
      .wr_width_en_i(wr_width_en_i), .wr_width_i(wr_width_i),
      .wr_half_i(wr_half_i), .wr_ratio_en_i(wr_ratio_en_i),
      .wr_ratio_i(wr_ratio_i), .wrap_i(wrap), .act_o(act_cfg)
   );

   fsg_period_ctr u_ctr (
      .clk(clk), .rst_n(rst_n), .n_i(act_cfg.ratio),
      .align_i(align_eff), .cnt_o(cnt), .wrap_o(wrap)
   );

   fsg_pulse_shaper #(.OUT_REG(OUT_REG)) u_shape (
      .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .cfg_i(act_cfg),
      .align_i(align_eff), .pol_i(pol_i), .fsync_o(fsync_o)
   );

   AST_CFG_AT_WRAP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> $stable(act_cfg)); // R7
   AST_CLOCK_MODE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_mode_i && !wrap) |=> (cnt == $past(cnt) + ratio_t'(1))); // R9

   if (!OUT_REG) begin : g_align_chk
      AST_ALIGN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
         (align_i && !clk_mode_i) |-> (fsync_o == pol_i)); // R8
   end
endmodule

// File: tb/tb_fsync_pulse_gen.sv
`timescale 1ns/1ps
module tb_fsync_pulse_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clk_mode = 1'b0, align = 1'b0, valid = 1'b1;
   logic       wr_w_en = 1'b0, wr_half = 1'b0, wr_r_en = 1'b0;
   logic [9:0] wr_width = '0, wr_ratio = '0;
   logic       pol = 1'b1;
   logic       fsync;
   int         n_chk = 0, n_bad = 0;

   always #2 clk = ~clk;

   fsync_pulse_gen dut (
      .clk(clk), .rst_n(rst_n), .clk_mode_i(clk_mode), .align_i(align),
      .cfg_valid_i(valid), .wr_width_en_i(wr_w_en), .wr_width_i(wr_width),
      .wr_half_i(wr_half), .wr_ratio_en_i(wr_r_en), .wr_ratio_i(wr_ratio),
      .pol_i(pol), .fsync_o(fsync)
   );

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(string tag, int k, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s cycle %0d: actual %b expected %b", tag, k, act, exp);
      end
   endtask

   function automatic logic lvl(bit active);
      return active ? pol : ~pol;
   endfunction

   task automatic run_pattern(string tag, int n, int w, int cycles, bit do_align);
      for (int k = 0; k < cycles; k++) begin
         tick();
         align = do_align && (k == 0);
         #1;
         chk(tag, k, fsync, lvl((k % n) < w));
      end
      tick();
      align = 1'b0;
   endtask

   task automatic load_cfg(int w, bit h, int r);
      tick(); valid = 1'b0;
      tick(); wr_w_en = 1'b1; wr_width = 10'(w); wr_half = h;
              wr_r_en = 1'b1; wr_ratio = 10'(r);
      tick(); wr_w_en = 1'b0; wr_r_en = 1'b0; valid = 1'b1;
      repeat (40) tick();
   endtask

   task automatic t_reset();
      pol = 1'b1;
      @(posedge clk); #1 rst_n = 1'b1;
      run_pattern("R1 reset ratio 8 width 1", 8, 1, 16, 1'b0);
   endtask

   task automatic t_basic();
      load_cfg(2, 1'b0, 5);
      run_pattern("R2 N=5 W=2 R8 align", 5, 2, 15, 1'b1);
      load_cfg(4, 1'b0, 9);
      run_pattern("R2 N=9 W=4", 9, 4, 27, 1'b1);
   endtask

   task automatic t_polarity();
      pol = 1'b0;
      run_pattern("R3 active low", 9, 4, 18, 1'b1);
      pol = 1'b1;
      run_pattern("R3 active high", 9, 4, 9, 1'b1);
   endtask

   task automatic t_half();
      load_cfg(1, 1'b1, 7);
      run_pattern("R4 half N=7", 7, 3, 21, 1'b1);
      load_cfg(1, 1'b1, 8);
      run_pattern("R4 half N=8", 8, 4, 16, 1'b1);
   endtask

   task automatic t_clamp();
      load_cfg(0, 1'b0, 6);
      run_pattern("R5 width 0 as 1", 6, 1, 12, 1'b1);
      load_cfg(9, 1'b0, 6);
      run_pattern("R5 width over N", 6, 5, 12, 1'b1);
      load_cfg(5, 1'b0, 1);
      run_pattern("R5 ratio 1 as 2", 2, 1, 8, 1'b1);
   endtask

   task automatic t_shadow();
      load_cfg(2, 1'b0, 6);
      tick(); valid = 1'b0;
      tick(); wr_w_en = 1'b1; wr_width = 10'd3; wr_r_en = 1'b1; wr_ratio = 10'd4;
      tick(); wr_w_en = 1'b0; wr_r_en = 1'b0;
      run_pattern("R7 old set kept while open", 6, 2, 18, 1'b1);
      for (int k = 0; k < 6 + 12; k++) begin
         tick();
         align = (k == 0);
         if (k == 0) valid = 1'b1;
         #1;
         if (k < 6) chk("R7 period before swap", k, fsync, lvl(k < 2));
         else       chk("R7 period after swap", k, fsync, lvl(((k - 6) % 4) < 3));
      end
      tick(); align = 1'b0;
      wr_w_en = 1'b1; wr_width = 10'd7; wr_r_en = 1'b1; wr_ratio = 10'd9;
      tick(); wr_w_en = 1'b0; wr_r_en = 1'b0; valid = 1'b0;
      tick(); valid = 1'b1;
      repeat (30) tick();
      run_pattern("R6 writes while valid ignored", 4, 3, 12, 1'b1);
   endtask

   task automatic t_clock_mode();
      load_cfg(2, 1'b0, 5);
      for (int k = 0; k < 20; k++) begin
         tick();
         clk_mode = (k >= 3);
         align = (k == 0) || (k == 7) || (k == 13);
         if (k == 12) pol = 1'b0;
         #1;
         chk("R9 align ignored in clock mode", k, fsync, lvl((k % 5) < 2));
      end
      tick(); align = 1'b0; clk_mode = 1'b0; pol = 1'b1;
   endtask

   initial begin
      #(4 * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) tick();
      t_reset();
      t_basic();
      t_polarity();
      t_half();
      t_clamp();
      t_shadow();
      t_clock_mode();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule